// File: doc/BRIEF.md
# Indirect Configuration Register Port

This block gives a host CPU's I/O bus indirect access to a small bank of 16-bit configuration registers. It has two ports. The host first writes a register number into the index port. Each later read or write of the data port then goes to the register that number selects. The index stays in place until it is written again, so the host can make several data accesses in a row to one register without rewriting the index.

The data port runs in one of two width modes, chosen by a strap input that is sampled only while reset is held. In narrow mode the port is 16 bits wide, and byte enables 2 and 3 have no meaning. In wide mode the port is 32 bits wide and all four byte enables are live. The upper half of every register is reserved, however, and must be written as zero. A wide write that carries a nonzero byte on an enabled reserved lane is taken as malformed and is dropped as a whole. In both modes the reserved and undefined read lanes are driven as zero. Register numbers beyond the implemented bank read as zero and ignore writes.

Top module: `cfg_index_port`

## Requirements
- R1: While reset is held and on its release, the index is 0 and register k holds 16'h5A00 + k, for every k below NUM_REGS (default 12).
- R2: An index-port write (io_port=0) with io_be[0]=1 loads the index from io_wdata[IDX_W-1:0]. With io_be[0]=0 the write leaves the index unchanged. An index-port read returns the index on io_rdata[IDX_W-1:0] and zero on all other bits.
- R3: The index keeps its value across any number of data-port accesses, and every data-port access uses the current index.
- R4: A data-port read (io_port=1) returns the selected register on io_rdata[15:0] and zero on io_rdata[31:16], in both modes. Whenever no read is requested (io_req=0 or io_write=1), io_rdata is all zero.
- R5: A data-port write changes register byte 0 only when io_be[0]=1 and byte 1 only when io_be[1]=1. A byte whose enable is low keeps its old value.
- R6: In narrow mode (strap 0), io_be[3:2] and io_wdata[31:16] have no effect on a data-port write.
- R7: In wide mode (strap 1), a data-port write that has io_be[2]=1 with io_wdata[23:16]!=0, or io_be[3]=1 with io_wdata[31:24]!=0, changes no register. A write whose enabled upper lanes carry zero is accepted normally on its lower lanes.
- R8: When the index is NUM_REGS or higher, a data-port read returns zero and a data-port write changes no register.
- R9: The width mode is taken from wide_mode_i only while rst_n is low. Changes to wide_mode_i after reset has been released have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the mode strap is sampled while it is low |
| wide_mode_i | input | 1 | Width-mode strap: 0 for a 16-bit data port, 1 for a 32-bit data port |
| io_req | input | 1 | Single-cycle I/O access strobe |
| io_write | input | 1 | 1 for a write, 0 for a read |
| io_port | input | 1 | 0 selects the index port, 1 selects the data port |
| io_be | input | 4 | Byte enables, one per data byte lane |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data; combinational while a read is requested, zero otherwise |

## Verification
The hardest situation to reach is the wide-mode rule for reserved lanes. It only has an effect when three conditions hold at once: the mode was strapped to wide during reset, an upper byte enable is set, and that lane carries nonzero data. The rule must also keep holding after the strap pin has been flipped back to narrow. To reach this, the stimulus resets the block with the strap high and sends writes that vary the upper lanes one at a time: a nonzero byte on an enabled lane, a nonzero byte on a disabled lane, and a zero byte on an enabled lane. It then lowers the strap during operation and repeats the rejected pattern. After each step the behavioural model checks the register through a data-port read.

// File: rtl/cip_pkg.sv
package cip_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned LANE_W = 8;

  typedef enum logic {
    PORT_INDEX = 1'b0,
    PORT_DATA  = 1'b1
  } port_e;

  // Value a configuration register takes at reset.
  function automatic logic [REG_W-1:0] reset_word(input int unsigned k);
    return 16'h5A00 + REG_W'(k);
  endfunction

  // True when a wide-mode write carries data on an enabled reserved lane.
  function automatic logic reserved_violation(input logic wide,
                                              input logic [3:0] be,
                                              input logic [BUS_W-1:0] d);
    logic bad;
    bad = (be[2] && (d[23:16] != 8'h00)) || (be[3] && (d[31:24] != 8'h00));
    return wide && bad;
  endfunction

  // Merge new bytes into an old word under per-byte write enables.
  function automatic logic [REG_W-1:0] merge_bytes(input logic [REG_W-1:0] old_w,
                                                   input logic [REG_W-1:0] new_w,
                                                   input logic [1:0] en);
    logic [REG_W-1:0] r;
    r[7:0]  = en[0] ? new_w[7:0]  : old_w[7:0];
    r[15:8] = en[1] ? new_w[15:8] : old_w[15:8];
    return r;
  endfunction
endpackage

// File: rtl/cip_index_reg.sv
module cip_index_reg #(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] din,
  output logic [IDX_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/cip_lane_gate.sv
module cip_lane_gate
  import cip_pkg::*;
(
  input  logic             mode_wide,
  input  logic             fire,
  input  logic [3:0]       be,
  input  logic [BUS_W-1:0] wdata,
  output logic [1:0]       byte_we,
  output logic             dropped
);
  logic viol;
  always_comb begin
    viol    = reserved_violation(mode_wide, be, wdata);
    dropped = fire && viol;
    byte_we = (fire && !viol) ? be[1:0] : 2'b00;
  end
endmodule

// File: rtl/cip_reg_bank.sv
module cip_reg_bank
  import cip_pkg::*;
#(
  parameter int unsigned NUM_REGS = 12,
  parameter int unsigned IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       byte_we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rd_word,
  output logic             in_range
);
  logic [REG_W-1:0] regs [NUM_REGS];

  assign in_range = ({1'b0, idx} < (IDX_W+1)'(NUM_REGS));

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic hit;
    assign hit = (idx == IDX_W'(k));
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[k] <= reset_word(k);
      else if (hit && (byte_we != 2'b00))
        regs[k] <= merge_bytes(regs[k], wdata, byte_we);
    end
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (idx == IDX_W'(k)) rd_word = regs[k];
  end
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cip_pkg::*;
#(
  parameter int unsigned NUM_REGS = 12,
  parameter int unsigned IDX_W    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wide_mode_i,
  input  logic        io_req,
  input  logic        io_write,
  input  logic        io_port,
  input  logic [3:0]  io_be,
  input  logic [31:0] io_wdata,
  output logic [31:0] io_rdata
);
  logic             mode_wide_q;
  logic [IDX_W-1:0] idx_q;
  logic             idx_load;
  logic             data_wr;
  logic             data_rd;
  logic             idx_rd;
  logic             wr_fire;
  logic             wr_dropped;
  logic [1:0]       byte_we;
  logic [REG_W-1:0] rd_word;
  logic             in_range;

  // Strap capture: only while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) mode_wide_q <= wide_mode_i;
  end

  assign idx_load = io_req && io_write && (io_port == PORT_INDEX) && io_be[0];
  assign idx_rd   = io_req && !io_write && (io_port == PORT_INDEX);
  assign data_wr  = io_req && io_write && (io_port == PORT_DATA);
  assign data_rd  = io_req && !io_write && (io_port == PORT_DATA);
  assign wr_fire  = data_wr && in_range;

  cip_index_reg #(.IDX_W(IDX_W)) u_idx (
    .clk  (clk),
    .rst_n(rst_n),
    .load (idx_load),
    .din  (io_wdata[IDX_W-1:0]),
    .q    (idx_q)
  );

  cip_lane_gate u_gate (
    .mode_wide(mode_wide_q),
    .fire     (wr_fire),
    .be       (io_be),
    .wdata    (io_wdata),
    .byte_we  (byte_we),
    .dropped  (wr_dropped)
  );

  cip_reg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx     (idx_q),
    .byte_we (byte_we),
    .wdata   (io_wdata[REG_W-1:0]),
    .rd_word (rd_word),
    .in_range(in_range)
  );

  always_comb begin
    io_rdata = '0;
    if (idx_rd)
      io_rdata[IDX_W-1:0] = idx_q;
    else if (data_rd && in_range)
      io_rdata[REG_W-1:0] = rd_word;
  end
endmodule

// File: rtl/cip_chk.sv
module cip_chk #(
  parameter int unsigned NUM_REGS = 12,
  parameter int unsigned IDX_W    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             io_req,
  input logic             io_write,
  input logic             io_port,
  input logic [3:0]       io_be,
  input logic [31:0]      io_rdata,
  input logic [IDX_W-1:0] idx_q,
  input logic             mode_wide_q,
  input logic [1:0]       byte_we,
  input logic             wr_dropped
);
  // R3
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_req && io_write && !io_port && io_be[0]) |=> $stable(idx_q));

  // R4
  rd_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_rdata[31:16] == 16'h0000);

  // R4
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_req && !io_write) |-> (io_rdata == 32'h0));

  // R8
  oob_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, idx_q} >= (IDX_W+1)'(NUM_REGS)) |-> (byte_we == 2'b00));

  // R8
  oob_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && !io_write && io_port && ({1'b0, idx_q} >= (IDX_W+1)'(NUM_REGS)))
      |-> (io_rdata == 32'h0));

  // R9
  mode_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(mode_wide_q));

  // R7
  drop_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dropped |-> (byte_we == 2'b00));

  // R6
  narrow_never_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wide_q |-> !wr_dropped);
endmodule

bind cfg_index_port cip_chk #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .io_req     (io_req),
  .io_write   (io_write),
  .io_port    (io_port),
  .io_be      (io_be),
  .io_rdata   (io_rdata),
  .idx_q      (idx_q),
  .mode_wide_q(mode_wide_q),
  .byte_we    (byte_we),
  .wr_dropped (wr_dropped)
);

// File: tb/cfg_index_port_test.sv
module cfg_index_port_test;
  localparam int NREG = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode_i = 1'b0;
  logic        io_req = 1'b0;
  logic        io_write = 1'b0;
  logic        io_port = 1'b0;
  logic [3:0]  io_be = 4'h0;
  logic [31:0] io_wdata = 32'h0;
  logic [31:0] io_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Behavioural model state
  int m_reg[NREG];
  int m_idx;
  bit m_wide;

  always #5 clk = ~clk;

  cfg_index_port uut (
    .clk(clk), .rst_n(rst_n), .wide_mode_i(wide_mode_i),
    .io_req(io_req), .io_write(io_write), .io_port(io_port),
    .io_be(io_be), .io_wdata(io_wdata), .io_rdata(io_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input bit wide);
    @(negedge clk);
    rst_n = 1'b0;
    wide_mode_i = wide;
    io_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_wide = wide;
    m_idx = 0;
    for (int k = 0; k < NREG; k++) m_reg[k] = 'h5A00 + k;
  endtask

  // One access: drive at negedge, check reads mid-cycle, update model at the edge,
  // then verify the idle bus reads zero.
  task automatic access(input bit port, input bit wr, input logic [3:0] be,
                        input logic [31:0] d, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    io_req = 1'b1; io_write = wr; io_port = port; io_be = be; io_wdata = d;
    #1;
    if (!wr) begin
      if (port == 1'b0) exp = 32'(m_idx);
      else if (m_idx < NREG) exp = 32'(m_reg[m_idx] & 'hFFFF);
      else exp = 32'h0;
      check(tag, io_rdata, exp);
    end
    @(posedge clk);
    if (wr) begin
      if (port == 1'b0) begin
        if (be[0]) m_idx = int'(d & 32'hF);
      end else if (m_idx < NREG) begin
        bit reject;
        reject = m_wide && ((be[2] && ((d >> 16) % 256) != 0) ||
                            (be[3] && (d >> 24) != 0));
        if (!reject) begin
          if (be[0]) m_reg[m_idx] = (m_reg[m_idx] / 256) * 256 + int'(d % 256);
          if (be[1]) m_reg[m_idx] = (m_reg[m_idx] % 256) + int'((d / 256) % 256) * 256;
        end
      end
    end
    @(negedge clk);
    io_req = 1'b0;
    #1;
    check({tag, " R4 idle"}, io_rdata, 32'h0);
  endtask

  task automatic sel(input int k);
    access(1'b0, 1'b1, 4'h1, 32'(k), "R2 set index");
  endtask

  task automatic rd_data(input string tag);
    access(1'b1, 1'b0, 4'hF, 32'h0, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // ---- narrow mode ----
    do_reset(1'b0);
    access(1'b0, 1'b0, 4'hF, 32'h0, "R1 index after reset");
    for (int k = 0; k < NREG; k++) begin
      sel(k);
      rd_data("R1 reset value");
    end
    sel(5);
    access(1'b0, 1'b0, 4'hF, 32'h0, "R2 index readback");
    access(1'b0, 1'b1, 4'hE, 32'h0000_0003, "R2 be0 low write");
    access(1'b0, 1'b0, 4'hF, 32'h0, "R2 index unchanged");
    // R5 byte lanes
    access(1'b1, 1'b1, 4'h3, 32'h0000_1234, "R5 full write");
    rd_data("R5 full word");
    access(1'b1, 1'b1, 4'h1, 32'h0000_ABCD, "R5 low byte");
    rd_data("R5 low byte only");
    access(1'b1, 1'b1, 4'h2, 32'h0000_EF00, "R5 high byte");
    rd_data("R5 high byte only");
    access(1'b1, 1'b1, 4'h0, 32'h0000_FFFF, "R5 no lanes");
    rd_data("R5 no lanes no change");
    // R3 repeated access to same index
    access(1'b1, 1'b1, 4'h3, 32'h0000_0101, "R3 write a");
    access(1'b1, 1'b1, 4'h1, 32'h0000_0077, "R3 write b");
    rd_data("R3 same register");
    rd_data("R3 repeated read");
    access(1'b0, 1'b0, 4'hF, 32'h0, "R3 index kept");
    // R6 narrow mode ignores upper lanes
    sel(2);
    access(1'b1, 1'b1, 4'hF, 32'hDEAD_4455, "R6 upper data");
    rd_data("R6 upper ignored");
    access(1'b1, 1'b1, 4'hC, 32'hFFFF_FFFF, "R6 only upper be");
    rd_data("R6 upper be no effect");
    // R8 out of range
    sel(12);
    rd_data("R8 oob read zero");
    access(1'b1, 1'b1, 4'h3, 32'h0000_BEEF, "R8 oob write");
    sel(15);
    access(1'b1, 1'b1, 4'h3, 32'h0000_BEEF, "R8 oob write 15");
    rd_data("R8 oob 15 read zero");
    for (int k = 0; k < NREG; k++) begin
      sel(k);
      rd_data("R8 bank untouched");
    end

    // ---- wide mode ----
    do_reset(1'b1);
    sel(1);
    rd_data("R1 reset after wide");
    access(1'b1, 1'b1, 4'hF, 32'h0000_2468, "R7 zero upper accepted");
    rd_data("R7 accepted");
    access(1'b1, 1'b1, 4'hF, 32'h0001_1111, "R7 nonzero lane2");
    rd_data("R7 lane2 drop");
    access(1'b1, 1'b1, 4'hB, 32'h0100_3333, "R7 nonzero lane3");
    rd_data("R7 lane3 drop");
    access(1'b1, 1'b1, 4'h3, 32'hFFFF_5555, "R7 upper disabled");
    rd_data("R7 disabled upper accepted");
    access(1'b1, 1'b1, 4'h7, 32'hFF00_6666, "R7 lane3 off lane2 zero");
    rd_data("R7 lane3 off accepted");
    // R9 strap change after reset has no effect
    @(negedge clk);
    wide_mode_i = 1'b0;
    access(1'b1, 1'b1, 4'hF, 32'h00AA_7777, "R9 still wide");
    rd_data("R9 strap ignored");
    access(1'b1, 1'b1, 4'hF, 32'h0000_8888, "R9 wide zero upper");
    rd_data("R9 wide accepts");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule